// File: doc/BRIEF.md
# Four-bit lookahead carry generator

This block is a purely combinational carry network for one group of four positions in a carry-lookahead adder. It takes a generate and a propagate signal for each of the four positions, plus the carry entering the group. From these it returns the carries into positions one, two and three, along with a group generate and a group propagate. Every output is a flat two-level AND-OR form, so the path from any input to any output is two gate levels deep.

The group pair exists so the unit can be cascaded into a lookahead tree. The same unit serves at every level of that tree: at higher levels its per-position inputs are the group pairs of four units below it. The carry out of the group is not an output. The level above forms it as group generate OR (group propagate AND carry-in). The block has no clock, no reset and no state.

Top module: `lookahead_carry_gen`

## Requirements
- R1: `carry_o[0]` equals `gen_i[0]` OR (`carry_i` AND `prop_i[0]`).
- R2: `carry_o[1]` equals `gen_i[1]` OR (`gen_i[0]` AND `prop_i[1]`) OR (`carry_i` AND `prop_i[0]` AND `prop_i[1]`).
- R3: `carry_o[2]` is the carry into position three, using the same sum-of-products pattern carried one position further.
- R4: `grp_gen_o` is high exactly when some position j generates a carry and every position above j, up to position three, propagates it. This output does not depend on `carry_i`.
- R5: `grp_prop_o` is high exactly when all four `prop_i` bits are high.
- R6: `grp_gen_o` OR (`grp_prop_o` AND `carry_i`) equals the carry out of position three that a bit-serial ripple chain gives for the same inputs.
- R7: Outputs depend only on the present inputs. The same input word gives the same outputs whatever inputs came before it.
- R8: With no generate bit set and all propagate bits high, all three carries equal `carry_i`.
- R9: A position whose generate and propagate are both low drives the carry into the next position low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gen_i | input | 4 | Per-position generate (bit or lower-level group) |
| prop_i | input | 4 | Per-position propagate (bit or lower-level group) |
| carry_i | input | 1 | Carry into position zero of the group |
| carry_o | output | 3 | Carries into positions one, two and three |
| grp_gen_o | output | 1 | Group generate across all four positions |
| grp_prop_o | output | 1 | Group propagate across all four positions |

## Verification
The assertions take the inputs to be known two-state values, and they are skipped while any input is unknown. They make no assumption about generate and propagate being mutually exclusive. The unit therefore has to be correct for inclusive-OR transfer signals as well as exclusive-OR propagate. The stimulus drives all 512 input words, which includes the pairs where both signals are high. It then replays the sweep in reverse order so that each word is reached from a different previous word.

// File: rtl/lcg_pkg.sv
package lcg_pkg;
  localparam int unsigned LCG_WIDTH   = 4;
  localparam int unsigned LCG_CARRIES = LCG_WIDTH - 1;
endpackage

// File: rtl/lcg_sop.sv
// Carry out of position HI as one flat AND-OR over gen[HI:0], prop[HI:0], ci.
module lcg_sop #(
  parameter int unsigned HI = 0
) (
  input  logic [HI:0] gen_i,
  input  logic [HI:0] prop_i,
  input  logic        ci_i,
  output logic        co_o
);
  localparam int unsigned NTERM = HI + 2;

  logic [NTERM-1:0] term;

  for (genvar j = 0; j <= HI; j++) begin : g_term
    // positions above j up to HI must propagate
    localparam logic [HI:0] MASK = {(HI+1){1'b1}} << (j + 1);
    assign term[j] = gen_i[j] & (&(prop_i | ~MASK));
  end

  assign term[HI+1] = ci_i & (&prop_i);
  assign co_o       = |term;

endmodule

// File: rtl/lcg_group.sv
module lcg_group #(
  parameter int unsigned WIDTH = lcg_pkg::LCG_WIDTH
) (
  input  logic [WIDTH-1:0] gen_i,
  input  logic [WIDTH-1:0] prop_i,
  output logic             grp_gen_o,
  output logic             grp_prop_o
);
  // group generate: same product terms with the carry-in term tied off
  lcg_sop #(.HI(WIDTH-1)) u_gen (
    .gen_i (gen_i),
    .prop_i(prop_i),
    .ci_i  (1'b0),
    .co_o  (grp_gen_o)
  );

  assign grp_prop_o = &prop_i;

  always_comb begin
    if (!$isunknown({gen_i, prop_i})) begin
      // R4: group generate needs the top position to generate or pass
      p_grp_gen_top_r4: assert (!grp_gen_o || gen_i[WIDTH-1] || prop_i[WIDTH-1])
        else $error("group generate without top position");
    end
  end

endmodule

// File: rtl/lookahead_carry_gen.sv
module lookahead_carry_gen #(
  parameter int unsigned WIDTH = lcg_pkg::LCG_WIDTH
) (
  input  logic [WIDTH-1:0] gen_i,
  input  logic [WIDTH-1:0] prop_i,
  input  logic             carry_i,
  output logic [WIDTH-2:0] carry_o,
  output logic             grp_gen_o,
  output logic             grp_prop_o
);
  localparam int unsigned NCARRY = WIDTH - 1;

  for (genvar k = 0; k < NCARRY; k++) begin : g_carry
    lcg_sop #(.HI(k)) u_sop (
      .gen_i (gen_i[k:0]),
      .prop_i(prop_i[k:0]),
      .ci_i  (carry_i),
      .co_o  (carry_o[k])
    );

    always_comb begin
      if (!$isunknown({gen_i, prop_i, carry_i})) begin
        // R1 R2 R3: a generating position always carries out
        p_gen_forces_carry_r1: assert (!gen_i[k] || carry_o[k])
          else $error("generate did not force carry %0d", k);
        // R9: a killing position blocks the carry
        p_kill_blocks_r9: assert (gen_i[k] || prop_i[k] || !carry_o[k])
          else $error("kill did not block carry %0d", k);
      end
    end
  end

  lcg_group #(.WIDTH(WIDTH)) u_group (
    .gen_i     (gen_i),
    .prop_i    (prop_i),
    .grp_gen_o (grp_gen_o),
    .grp_prop_o(grp_prop_o)
  );

  always_comb begin
    if (!$isunknown({gen_i, prop_i, carry_i})) begin
      // R8: full transparency passes carry_i to every carry
      p_transparent_r8: assert (!(grp_prop_o && gen_i == '0) || carry_o == {NCARRY{carry_i}})
        else $error("transparent chain mismatch");
      // R5: group propagate means no position kills
      p_grp_prop_r5: assert (!grp_prop_o || !(carry_i && gen_i == '0) || (&carry_o))
        else $error("group propagate with killed carry");
      // R6: group generate implies the top carry path is live
      p_grp_gen_top_r6: assert (!grp_gen_o || gen_i[WIDTH-1] || carry_o[NCARRY-1])
        else $error("group generate without top carry");
    end
  end

endmodule

// File: tb/lookahead_carry_gen_bench.sv
module lookahead_carry_gen_bench;
  localparam int W = 4;

  typedef struct {
    logic [W-1:0] g;
    logic [W-1:0] p;
    logic         c;
    logic [W-2:0] exp_c;
    logic         exp_gg;
    logic         exp_gp;
    logic         exp_co;
    string        tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] gen_i = '0;
  logic [W-1:0] prop_i = '0;
  logic carry_i = 1'b0;
  logic [W-2:0] carry_o;
  logic grp_gen_o, grp_prop_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  item_t sb[$];

  always #5 clk = ~clk;

  lookahead_carry_gen u_lookahead_carry_gen (
    .gen_i     (gen_i),
    .prop_i    (prop_i),
    .carry_i   (carry_i),
    .carry_o   (carry_o),
    .grp_gen_o (grp_gen_o),
    .grp_prop_o(grp_prop_o)
  );

  task automatic chk(input string req, input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, tag, act, exp);
    end
  endtask

  // ripple reference
  task automatic drive(input logic [W-1:0] g, input logic [W-1:0] p, input logic c, input string tag);
    item_t it;
    logic [W:0] rc;
    logic gc;
    rc[0] = c;
    for (int k = 0; k < W; k++) rc[k+1] = g[k] | (p[k] & rc[k]);
    gc = 1'b0;
    for (int k = 0; k < W; k++) gc = g[k] | (p[k] & gc);
    it.g = g; it.p = p; it.c = c;
    it.exp_c = rc[W-1:1];
    it.exp_gg = gc;
    it.exp_gp = &p;
    it.exp_co = rc[W];
    it.tag = tag;
    @(posedge clk);
    gen_i <= g; prop_i <= p; carry_i <= c;
    sb.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        chk("R1", it.tag, {3'b0, carry_o[0]}, {3'b0, it.exp_c[0]});
        chk("R2", it.tag, {3'b0, carry_o[1]}, {3'b0, it.exp_c[1]});
        chk("R3", it.tag, {3'b0, carry_o[2]}, {3'b0, it.exp_c[2]});
        chk("R4", it.tag, {3'b0, grp_gen_o}, {3'b0, it.exp_gg});
        chk("R5", it.tag, {3'b0, grp_prop_o}, {3'b0, it.exp_gp});
        chk("R6", it.tag, {3'b0, grp_gen_o | (grp_prop_o & it.c)}, {3'b0, it.exp_co});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    drive('0, '0, 1'b0, "idle zero");
    drive(4'b0000, 4'b1111, 1'b1, "R8 transparent ci=1");
    drive(4'b0000, 4'b1111, 1'b0, "R8 transparent ci=0");
    drive(4'b0101, 4'b0000, 1'b1, "R9 kill odd");
    drive(4'b0000, 4'b0000, 1'b1, "R9 kill all");
    for (int v = 0; v < 512; v++)
      drive(v[8:5], v[4:1], v[0], "sweep up");
    for (int v = 511; v >= 0; v--)
      drive(v[8:5], v[4:1], v[0], "R7 sweep down");
    drive(4'b1111, 4'b1111, 1'b0, "R7 after history");
    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule